// File: doc/BRIEF.md
# Serial Audio Receive Lane with Sample-Pair Queue

This block is one receive lane of a serial audio port. It watches a bit-clock strobe, a word-select level and a serial data line, rebuilds one left and one right sample per frame, and queues each completed left/right pair in a 16-entry buffer. The clock strobe (`sck_tick`) is a single-cycle pulse in the system clock domain that marks each rising bit-clock edge. Generating that strobe, decoding register accesses and DMA handshakes all happen outside this block.

Three framing formats are supported: the classic format, where the MSB follows the word-select change by one bit clock; a format where the MSB is sent on the same bit clock as the word-select change; and a format where the LSB is the last bit before the next word-select change. The sample width can be set to 12, 16, 20, 24 or 32 bits. The queue drains through a valid/ready stream. The left half of the head pair is a plain view. A transfer on the stream, which is the right-register read, removes the whole pair. Back-pressure has no effect on capture. When the queue is full and nothing is taken in the same cycle, a newly completed pair is dropped. The old contents stay, and an overrun flag is latched.

Two status bits, data-available and overrun, are masked into one interrupt line. A separate strobe reads and clears the overrun flag. The queue can be emptied with a lane flush or a port-wide flush.

Top module: `i2s_rx_lane`

## Requirements
- R1: A pair is captured only while `blk_rx_en` and `lane_en` are both 1. While either is 0, bit strobes add nothing to the queue, and the partial frame state is cleared.
- R2: `res_sel` sets the sample width: 1=12, 2=16, 3=20, 4=24, 5=32 bits. Codes 0, 6 and 7 keep up to 32 bits. The kept bits are right-justified, and the upper bits read 0. A slot shorter than the width yields all of its bits.
- R3: With `fmt_sel` bit 0 set (3'b001, classic format), the MSB is sampled on the strobe after a word-select change. The first width-many bits of the slot are kept, and the slot ends with the bit sampled on the next word-select change.
- R4: With `fmt_sel`=3'b100 (MSB-at-edge format), the MSB is sampled on the same strobe as the word-select change, and the first width-many bits of the slot are kept.
- R5: With `fmt_sel`=3'b010 (LSB-at-edge format), the last width-many bits before the next word-select change are kept.
- R6: `ws_in`=0 marks the left slot and 1 the right slot. A pair is queued when a right slot completes after a left slot. A right slot with no preceding left slot is dropped, and so is the first slot after capture is enabled.
- R7: The queue holds 16 pairs. `out_valid` is 1 while it is non-empty, and `out_left`/`out_right` show the oldest pair. A pop happens on `out_valid && out_ready`. Nothing else removes data, except a flush.
- R8: A pair that completes while the queue is full and no pop occurs in the same cycle is dropped, the contents are kept, and `status[1]` (overrun) is set. If a pop occurs in the same cycle, the pair is accepted.
- R9: A one-cycle `ovr_rd` pulse clears the overrun flag. A new overrun in the same cycle wins, and the flag stays 1.
- R10: `status[0]` (data available) is 1 when the fill level is at least `trig_sel`+1.
- R11: `irq` is 1 when any status bit is 1 and its `irq_mask` bit at the same position is 0. A mask bit of 1 blocks that status bit.
- R12: `flush_lane` or `flush_all` empties the queue at the next edge. A pair completing in that cycle is discarded and does not set overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_tick | input | 1 | One-cycle strobe per rising bit-clock edge |
| ws_in | input | 1 | Word-select level (0 left, 1 right) |
| sd_in | input | 1 | Serial data, MSB first |
| blk_rx_en | input | 1 | Port-wide receive enable |
| lane_en | input | 1 | Enable for this lane |
| res_sel | input | 3 | Sample width code |
| fmt_sel | input | 3 | One-hot framing format |
| trig_sel | input | TW (4) | Data-available threshold, fill >= code+1 |
| flush_lane | input | 1 | Empty this lane's queue |
| flush_all | input | 1 | Port-wide flush, empties this queue |
| out_valid | output | 1 | Queue non-empty |
| out_ready | input | 1 | Consumer takes the head pair |
| out_left | output | SW (32) | Left sample of the head pair |
| out_right | output | SW (32) | Right sample of the head pair |
| ovr_rd | input | 1 | Overrun read-and-clear strobe |
| irq_mask | input | 2 | Interrupt mask, bit 0 data-available, bit 1 overrun |
| status | output | 2 | Bit 0 data-available, bit 1 overrun |
| irq | output | 1 | Masked interrupt |

## Verification
Three pairs of events can fall in one clock edge, and each is provoked by driving a control strobe on the exact strobe cycle in which a right slot completes. A pop on the full queue, when it meets a completed pair, must accept the pair without raising overrun. An overrun read, when it meets a drop, must leave the flag set. A lane flush, when it meets a completed pair, must leave the queue empty and the flag clear. A behavioural queue model in the bench, updated on every edge, judges each of these cases. The bench compares the stream outputs, both status bits and the interrupt with that model on every cycle.

// File: rtl/i2s_rx_pkg.sv
`timescale 1ns/1ps
package i2s_rx_pkg;

  typedef enum logic [1:0] {
    FMT_STD   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2
  } fmt_e;

  // One-hot format select: bit 0 wins, then bit 1, anything else is MSB-at-edge
  function automatic fmt_e fmt_of(logic [2:0] sel);
    if (sel[0]) return FMT_STD;
    if (sel[1]) return FMT_RIGHT;
    return FMT_LEFT;
  endfunction

  function automatic int unsigned res_width(logic [2:0] code, int unsigned cap);
    int unsigned w;
    case (code)
      3'd1:    w = 12;
      3'd2:    w = 16;
      3'd3:    w = 20;
      3'd4:    w = 24;
      default: w = 32;
    endcase
    return (w > cap) ? cap : w;
  endfunction

endpackage

// File: rtl/i2s_rx_deser.sv
`timescale 1ns/1ps
module i2s_rx_deser
  import i2s_rx_pkg::*;
#(
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          sck_tick,
  input  logic          ws_in,
  input  logic          sd_in,
  input  logic [2:0]    res_sel,
  input  logic [2:0]    fmt_sel,
  output logic          push,
  output logic [SW-1:0] push_l,
  output logic [SW-1:0] push_r
);
  localparam int CW = $clog2(SW + 1);

  fmt_e          fm;
  logic [CW-1:0] nres;
  logic [SW-1:0] rmask;
  logic          ws_q, started, have_l;
  logic [SW-1:0] acc, acc_sh, hold_l, fin_word;
  logic [CW-1:0] cnt, cnt_sh;
  logic          take, ws_edge, fin_ok;

  assign fm   = fmt_of(fmt_sel);
  assign nres = CW'(res_width(res_sel, SW));

  always_comb begin
    for (int i = 0; i < SW; i++) rmask[i] = (CW'(i) < nres);
  end

  // LSB-at-edge keeps a sliding window; the other formats stop after nres bits
  assign take     = (fm == FMT_RIGHT) || (cnt < nres);
  assign acc_sh   = take ? ({acc[SW-2:0], sd_in} & rmask) : acc;
  assign cnt_sh   = (cnt < nres) ? cnt + CW'(1) : cnt;
  assign ws_edge  = sck_tick && cap_en && (ws_in != ws_q);
  // Classic format: the bit on the edge strobe still belongs to the old slot
  assign fin_word = (fm == FMT_STD) ? acc_sh : acc;
  assign fin_ok   = ws_edge && started;

  assign push   = fin_ok && ws_q && have_l;
  assign push_l = hold_l;
  assign push_r = fin_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q    <= 1'b0;
      started <= 1'b0;
      have_l  <= 1'b0;
      acc     <= '0;
      cnt     <= '0;
      hold_l  <= '0;
    end else begin
      if (sck_tick) ws_q <= ws_in;
      if (!cap_en) begin
        started <= 1'b0;
        have_l  <= 1'b0;
        acc     <= '0;
        cnt     <= '0;
      end else if (sck_tick) begin
        if (ws_in != ws_q) begin
          started <= 1'b1;
          if (started) begin
            if (!ws_q) begin
              hold_l <= fin_word;
              have_l <= 1'b1;
            end else begin
              have_l <= 1'b0;
            end
          end
          if (fm == FMT_STD) begin
            acc <= '0;
            cnt <= '0;
          end else begin
            acc <= {{(SW-1){1'b0}}, sd_in};
            cnt <= CW'(1);
          end
        end else begin
          acc <= acc_sh;
          cnt <= cnt_sh;
        end
      end
    end
  end

endmodule

// File: rtl/i2s_rx_pairq.sv
`timescale 1ns/1ps
module i2s_rx_pairq #(
  parameter int W     = 64,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         wr_v,
  input  logic [W-1:0]                 wr_d,
  input  logic                         rd_ready,
  output logic                         rd_v,
  output logic [W-1:0]                 rd_d,
  output logic [$clog2(DEPTH+1)-1:0]   fill,
  output logic                         drop
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [AW-1:0]   wptr, rptr;
  logic [CNTW-1:0] cnt;
  logic            full, pop, accept;
  logic [W-1:0]    slot_bus [DEPTH];

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full   = (cnt == CNTW'(DEPTH));
  assign pop    = rd_ready && (cnt != '0);
  assign accept = wr_v && (!full || pop) && !flush;
  assign drop   = wr_v && full && !pop && !flush;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (accept && wptr == AW'(g)) slot_q <= wr_d;
    end
    assign slot_bus[g] = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (accept) wptr <= nxt(wptr);
      if (pop)    rptr <= nxt(rptr);
      cnt <= cnt + CNTW'(accept) - CNTW'(pop);
    end
  end

  assign rd_v = (cnt != '0);
  assign rd_d = slot_bus[rptr];
  assign fill = cnt;

endmodule

// File: rtl/i2s_rx_flags.sv
`timescale 1ns/1ps
module i2s_rx_flags #(
  parameter int CNTW = 5,
  parameter int TW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CNTW-1:0] fill,
  input  logic [TW-1:0]   trig,
  input  logic            drop,
  input  logic            ovr_rd,
  input  logic [1:0]      mask,
  output logic [1:0]      status,
  output logic            irq
);
  logic ovr_q;

  // A drop in the same cycle as the read keeps the flag set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovr_q <= 1'b0;
    else if (drop)   ovr_q <= 1'b1;
    else if (ovr_rd) ovr_q <= 1'b0;
  end

  assign status = {ovr_q, (fill > CNTW'(trig))};
  assign irq    = |(status & ~mask);

endmodule

// File: rtl/i2s_rx_lane.sv
`timescale 1ns/1ps
module i2s_rx_lane
  import i2s_rx_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int SW    = 32,
  localparam int TW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_tick,
  input  logic          ws_in,
  input  logic          sd_in,
  input  logic          blk_rx_en,
  input  logic          lane_en,
  input  logic [2:0]    res_sel,
  input  logic [2:0]    fmt_sel,
  input  logic [TW-1:0] trig_sel,
  input  logic          flush_lane,
  input  logic          flush_all,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_left,
  output logic [SW-1:0] out_right,
  input  logic          ovr_rd,
  input  logic [1:0]    irq_mask,
  output logic [1:0]    status,
  output logic          irq
);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic            cap_en, flush_any;
  logic            w_push, w_drop;
  logic [SW-1:0]   w_l, w_r;
  logic [2*SW-1:0] w_head;
  logic [CNTW-1:0] w_fill;

  assign cap_en    = blk_rx_en & lane_en;
  assign flush_any = flush_lane | flush_all;

  i2s_rx_deser #(.SW(SW)) u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .sck_tick (sck_tick),
    .ws_in    (ws_in),
    .sd_in    (sd_in),
    .res_sel  (res_sel),
    .fmt_sel  (fmt_sel),
    .push     (w_push),
    .push_l   (w_l),
    .push_r   (w_r)
  );

  i2s_rx_pairq #(.W(2*SW), .DEPTH(DEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_any),
    .wr_v     (w_push),
    .wr_d     ({w_l, w_r}),
    .rd_ready (out_ready),
    .rd_v     (out_valid),
    .rd_d     (w_head),
    .fill     (w_fill),
    .drop     (w_drop)
  );

  i2s_rx_flags #(.CNTW(CNTW), .TW(TW)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .fill   (w_fill),
    .trig   (trig_sel),
    .drop   (w_drop),
    .ovr_rd (ovr_rd),
    .mask   (irq_mask),
    .status (status),
    .irq    (irq)
  );

  assign out_left  = w_head[2*SW-1:SW];
  assign out_right = w_head[SW-1:0];

endmodule

// File: rtl/i2s_rx_lane_chk.sv
`timescale 1ns/1ps
module i2s_rx_lane_chk #(
  parameter  int DEPTH = 16,
  parameter  int SW    = 32,
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            blk_rx_en,
  input logic            lane_en,
  input logic            flush_lane,
  input logic            flush_all,
  input logic            out_valid,
  input logic            out_ready,
  input logic [SW-1:0]   out_left,
  input logic [SW-1:0]   out_right,
  input logic            ovr_rd,
  input logic [1:0]      irq_mask,
  input logic [1:0]      status,
  input logic            irq,
  input logic            w_push,
  input logic [CNTW-1:0] fill
);
  logic flush_any, lost;
  assign flush_any = flush_lane | flush_all;
  assign lost      = w_push && (fill == CNTW'(DEPTH)) && !out_ready && !flush_any;

  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_rx_en && lane_en) |-> !w_push);

  p_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !w_push && !flush_any) |=> (fill == $past(fill) - CNTW'(1)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> (fill == CNTW'(DEPTH)) && $stable(out_left) && $stable(out_right));

  p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> status[1]);

  p_ovr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_rd && !lost) |=> !status[1]);

  p_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (&irq_mask) |-> !irq);

  p_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flush_any |=> (!out_valid && !status[0]));

endmodule

bind i2s_rx_lane i2s_rx_lane_chk #(.DEPTH(DEPTH), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .blk_rx_en  (blk_rx_en),
  .lane_en    (lane_en),
  .flush_lane (flush_lane),
  .flush_all  (flush_all),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_left   (out_left),
  .out_right  (out_right),
  .ovr_rd     (ovr_rd),
  .irq_mask   (irq_mask),
  .status     (status),
  .irq        (irq),
  .w_push     (w_push),
  .fill       (w_fill)
);

// File: tb/i2s_rx_lane_test.sv
`timescale 1ns/1ps
module i2s_rx_lane_test;
  localparam int DEPTH = 16;
  localparam int SW    = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 8 ns period

  logic        sck_tick = 0, ws_in = 0, sd_in = 0;
  logic        blk_rx_en = 1, lane_en = 1;
  logic [2:0]  res_sel = 3'd2, fmt_sel = 3'b001;
  logic [3:0]  trig_sel = 4'd0;
  logic        flush_lane = 0, flush_all = 0, out_ready = 0, ovr_rd = 0;
  logic [1:0]  irq_mask = 2'b00;
  logic        out_valid, irq;
  logic [SW-1:0] out_left, out_right;
  logic [1:0]  status;

  i2s_rx_lane #(.DEPTH(DEPTH), .SW(SW)) uut (
    .clk(clk), .rst_n(rst_n), .sck_tick(sck_tick), .ws_in(ws_in), .sd_in(sd_in),
    .blk_rx_en(blk_rx_en), .lane_en(lane_en), .res_sel(res_sel), .fmt_sel(fmt_sel),
    .trig_sel(trig_sel), .flush_lane(flush_lane), .flush_all(flush_all),
    .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left),
    .out_right(out_right), .ovr_rd(ovr_rd), .irq_mask(irq_mask),
    .status(status), .irq(irq)
  );

  typedef struct { logic [31:0] l; logic [31:0] r; } pr_t;

  pr_t   q[$];
  bit    m_ovr = 0;
  bit    exp_push = 0;
  pr_t   exp_pair;
  bit    opt_pop = 0, opt_clr = 0, opt_flush = 0;
  int    total = 0, bad = 0;
  string cur_tag = "R7";
  bit    done = 0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: a queue of pairs and an overrun bit, advanced on every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_ovr = 0;
    end else begin
      bit set_o;
      set_o = 0;
      if (flush_lane || flush_all) begin
        q.delete();
      end else begin
        if (out_ready && q.size() > 0) void'(q.pop_front());
        if (exp_push) begin
          if (q.size() < DEPTH) q.push_back(exp_pair);
          else set_o = 1;
        end
      end
      if (set_o) m_ovr = 1;
      else if (ovr_rd) m_ovr = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [1:0] es;
      es = {m_ovr, (q.size() > int'(trig_sel))};
      chk(out_valid == (q.size() != 0), {cur_tag, " R7 valid"}, out_valid, q.size() != 0);
      if (q.size() != 0) begin
        chk(out_left == q[0].l, {cur_tag, " left sample"}, out_left, q[0].l);
        chk(out_right == q[0].r, {cur_tag, " right sample"}, out_right, q[0].r);
      end
      chk(status[0] == es[0], "R10 data-available", status[0], es[0]);
      chk(status[1] == es[1], "R8 overrun flag", status[1], es[1]);
      chk(irq == |(es & ~irq_mask), "R11 irq", irq, |(es & ~irq_mask));
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic logic [31:0] pat(int seed, int k, int slen);
    logic [31:0] v;
    v = 32'(seed) * 32'h9E3779B1 + 32'(k) * 32'h7F4A7C15 + 32'h01234567;
    if (slen < 32) v = v & ((32'd1 << slen) - 32'd1);
    return v;
  endfunction

  // Expected capture from the requirements, at word level
  function automatic logic [31:0] want(logic [31:0] p, int slen);
    int r, n;
    logic [63:0] pw, m;
    case (res_sel)
      3'd1: r = 12;
      3'd2: r = 16;
      3'd3: r = 20;
      3'd4: r = 24;
      default: r = 32;
    endcase
    n  = (slen < r) ? slen : r;
    pw = {32'd0, p};
    m  = (64'd1 << n) - 64'd1;
    if (fmt_sel == 3'b010) return 32'(pw & m);
    return 32'((pw >> (slen - n)) & m);
  endfunction

  task automatic burst(int npairs, int slen, int seed, bit lane);
    bit  wsb[$];
    bit  bb[$];
    int  pidx[$];
    pr_t pv[$];
    int  k;
    logic [31:0] lp, rp;
    pr_t pp;
    for (int i = 0; i < 2; i++) begin wsb.push_back(1); bb.push_back(0); end
    for (int i = 0; i < npairs; i++) begin
      lp = pat(seed, 2*i, slen);
      rp = pat(seed, 2*i + 1, slen);
      for (int j = 0; j < slen; j++) begin wsb.push_back(0); bb.push_back(lp[slen-1-j]); end
      for (int j = 0; j < slen; j++) begin wsb.push_back(1); bb.push_back(rp[slen-1-j]); end
      pidx.push_back(2 + (2*i + 2) * slen);
      pp.l = want(lp, slen);
      pp.r = want(rp, slen);
      pv.push_back(pp);
    end
    wsb.push_back(0);
    bb.push_back(0);
    step();
    lane_en = 0;
    step();
    lane_en = lane;
    k = 0;
    for (int t = 0; t < wsb.size(); t++) begin
      step();
      ws_in    = wsb[t];
      sd_in    = (fmt_sel == 3'b001) ? ((t == 0) ? 1'b0 : bb[t-1]) : bb[t];
      sck_tick = 1;
      if (k < pidx.size() && pidx[k] == t) begin
        exp_push   = lane && blk_rx_en;
        exp_pair   = pv[k];
        out_ready  = opt_pop;
        ovr_rd     = opt_clr;
        flush_lane = opt_flush;
        k++;
      end
      step();
      sck_tick = 0; exp_push = 0; out_ready = 0; ovr_rd = 0; flush_lane = 0;
    end
  endtask

  task automatic drain();
    step();
    out_ready = 1;
    repeat (DEPTH + 2) step();
    out_ready = 0;
  endtask

  initial begin
    repeat (4) step();
    rst_n = 1;
    step();
    chk(!out_valid && status == 2'b00 && !irq, "R7 reset state", {out_valid, status, irq}, 0);

    cur_tag = "R3"; fmt_sel = 3'b001; res_sel = 3'd2;
    burst(3, 32, 1, 1); drain();

    cur_tag = "R4"; fmt_sel = 3'b100; res_sel = 3'd1;
    burst(2, 16, 2, 1); drain();

    cur_tag = "R5"; fmt_sel = 3'b010; res_sel = 3'd3;
    burst(2, 24, 3, 1);
    res_sel = 3'd5;
    burst(2, 32, 4, 1); drain();

    cur_tag = "R2"; fmt_sel = 3'b100; res_sel = 3'd0;
    burst(2, 16, 5, 1);
    fmt_sel = 3'b001; res_sel = 3'd7;
    burst(1, 32, 6, 1);
    fmt_sel = 3'b100; res_sel = 3'd4;
    burst(1, 20, 7, 1); drain();

    cur_tag = "R1"; res_sel = 3'd2;
    burst(2, 16, 8, 0);
    blk_rx_en = 0;
    burst(2, 16, 9, 1);
    step();
    chk(!out_valid, "R1 disabled capture", out_valid, 0);
    blk_rx_en = 1;

    cur_tag = "R6";
    burst(1, 16, 10, 1);
    step();
    chk(out_valid, "R6 single pair queued", out_valid, 1);
    drain();

    cur_tag = "R10"; trig_sel = 4'd3;
    burst(17, 16, 11, 1);
    step();
    chk(status[1], "R8 overrun after 17 pairs", status[1], 1);

    cur_tag = "R11";
    for (int m = 0; m < 4; m++) begin
      irq_mask = 2'(m);
      step();
      step();
    end
    chk(!irq, "R11 fully masked", irq, 0);
    irq_mask = 2'b00;

    cur_tag = "R9";
    step(); ovr_rd = 1; step(); ovr_rd = 0; step();
    chk(!status[1], "R9 read clears overrun", status[1], 0);

    cur_tag = "R8"; opt_pop = 1;
    burst(1, 16, 12, 1);
    opt_pop = 0;
    step();
    chk(!status[1], "R8 pop at full accepts pair", status[1], 0);

    cur_tag = "R9"; opt_clr = 1;
    burst(1, 16, 13, 1);
    opt_clr = 0;
    step();
    chk(status[1], "R9 overrun wins over clear", status[1], 1);
    ovr_rd = 1; step(); ovr_rd = 0;

    cur_tag = "R12"; opt_flush = 1;
    burst(1, 16, 14, 1);
    opt_flush = 0;
    step();
    chk(!out_valid && !status[1], "R12 flush at push", {out_valid, status[1]}, 0);
    burst(2, 16, 15, 1);
    step(); flush_all = 1; step(); flush_all = 0; step();
    chk(!out_valid, "R12 port-wide flush", out_valid, 0);

    cur_tag = "R7"; trig_sel = 4'd0;
    burst(1, 16, 16, 1); drain();

    step();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule